// File: doc/BRIEF.md
# Two-Bank Symbol Histogram

This block keeps a histogram of a stream of received symbols so that link errors can be studied offline. Every valid symbol taken on the sample clock selects a counter, which is read, incremented and written back. The counters live in on-chip RAM with a one-cycle read latency. Valid words alternate between two banks. The first valid word after reset or after a clear goes to bank 0, the next to bank 1, and so on. Each bank therefore sees at most one update every other cycle, and the block still accepts a new symbol on every sample-clock cycle. The true count for a symbol is the sum of the two banks, and that sum is formed outside the block.

A second port on the system clock reads both banks at one index and returns the two counts together after a fixed latency. The same port can start a clear. The request crosses into the sample-clock domain, where a sweep writes zero to every address of both banks. The completion is then handed back, and a busy flag stays high on the system side until the sweep has finished.

Top module: `pattern_hist`

## Requirements
- R1: Each bank holds 2^SYM_W counters, 1024 with the default SYM_W of 10. A valid word (`sym_vld` high) increments the counter at index `sym` in exactly one bank. Indices that receive no words keep a count of 0.
- R2: Counters are CNT_W wide, 16 bits by default. They stop at 65535 and never wrap to zero.
- R3: Valid words are numbered from 0 after reset and after each clear. Even-numbered words update bank 0, which is read on `rd_cnt0`, and odd-numbered words update bank 1, which is read on `rd_cnt1`. Cycles with `sym_vld` low do not advance the numbering.
- R4: One word per sample-clock cycle is accepted indefinitely. This includes the same symbol on consecutive cycles, which updates the same counter in a bank two cycles apart, and no count is lost.
- R5: When `rd_en` is high on a system-clock edge with index `rd_idx`, `rd_vld` is high exactly two system-clock edges later for one cycle. In that cycle `rd_cnt0` and `rd_cnt1` carry the bank-0 and bank-1 counts at that index. `rd_vld` is low at all other times.
- R6: When `clr_req` is high on a system-clock edge while `clr_busy` is low, `clr_busy` rises after that edge. It stays high until every counter in both banks has been zeroed, and then falls.
- R7: Words that arrive while the sweep is running are not counted. The first valid word after the sweep goes to bank 0.
- R8: During and right after reset, `rd_vld` and `clr_busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| samp_clk | input | 1 | Sample clock for symbol updates and for the clear sweep |
| samp_rst_n | input | 1 | Asynchronous active-low reset, sample domain |
| sym_vld | input | 1 | Symbol strobe |
| sym | input | SYM_W | Received symbol, used as the counter index |
| sys_clk | input | 1 | System clock for reads and clear requests |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| rd_en | input | 1 | Read request |
| rd_idx | input | SYM_W | Counter index to read |
| rd_vld | output | 1 | Read data valid, two cycles after `rd_en` |
| rd_cnt0 | output | CNT_W | Bank-0 count at the requested index |
| rd_cnt1 | output | CNT_W | Bank-1 count at the requested index |
| clr_req | input | 1 | Clear request pulse |
| clr_busy | output | 1 | Clear in progress |

## Verification
The bank checks assume that the steering logic never hits the same bank on two cycles in a row. They also assume that `rd_en` and `clr_req` change only with the system clock, that `sym_vld` changes only with the sample clock, and that both clocks run throughout a clear. The stimulus drives every input on the falling edge of its own clock. It issues reads only after the update pipeline has drained, and it raises `clr_req` only while `clr_busy` is low. The sweep test sends a late-swept index while the sweep is running. Whether each of those words lands before or during the sweep, the expected count after the clear is zero.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int NUM_BANKS = 2;

  typedef enum logic {
    SWP_IDLE = 1'b0,
    SWP_RUN  = 1'b1
  } swp_state_t;
endpackage

// File: rtl/hist_clr.sv
module hist_clr #(
  parameter int SYM_W = 10
) (
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             clr_req,
  output logic             clr_busy,
  input  logic             samp_clk,
  input  logic             samp_rst_n,
  output logic             sweep_on,
  output logic [SYM_W-1:0] sweep_addr
);
  import hist_pkg::*;

  localparam logic [SYM_W-1:0] LAST = '1;

  // system side: request toggle, returned completion toggle
  logic req_tgl, req_tgl_d;
  logic done_m, done_s;
  logic done_tgl, done_d;

  assign clr_busy = req_tgl ^ done_s;

  always_comb begin
    req_tgl_d = req_tgl ^ (clr_req & ~clr_busy);
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_tgl <= 1'b0;
      done_m  <= 1'b0;
      done_s  <= 1'b0;
    end else begin
      req_tgl <= req_tgl_d;
      done_m  <= done_tgl;
      done_s  <= done_m;
    end
  end

  // sample side: request synchronizer and address sweep
  logic             req_m, req_s, req_seen;
  logic             start;
  swp_state_t       state, state_d;
  logic [SYM_W-1:0] addr, addr_d;

  assign start = req_s ^ req_seen;

  always_comb begin
    state_d = state;
    addr_d  = addr;
    done_d  = done_tgl;
    unique case (state)
      SWP_IDLE: begin
        if (start) begin
          state_d = SWP_RUN;
          addr_d  = '0;
        end
      end
      SWP_RUN: begin
        if (addr == LAST) begin
          state_d = SWP_IDLE;
          done_d  = ~done_tgl;
        end else begin
          addr_d = addr + 1'b1;
        end
      end
      default: state_d = SWP_IDLE;
    endcase
  end

  always_ff @(posedge samp_clk or negedge samp_rst_n) begin
    if (!samp_rst_n) begin
      req_m    <= 1'b0;
      req_s    <= 1'b0;
      req_seen <= 1'b0;
      state    <= SWP_IDLE;
      addr     <= '0;
      done_tgl <= 1'b0;
    end else begin
      req_m    <= req_tgl;
      req_s    <= req_m;
      req_seen <= req_s;
      state    <= state_d;
      addr     <= addr_d;
      done_tgl <= done_d;
    end
  end

  assign sweep_on   = (state == SWP_RUN);
  assign sweep_addr = addr;

  // R6
  busy_rise_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (clr_req && !clr_busy) |=> clr_busy);

  // R6
  sweep_end_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    (state == SWP_RUN && addr == LAST) |=> (state == SWP_IDLE && done_tgl != $past(done_tgl)));
endmodule

// File: rtl/hist_bank.sv
module hist_bank #(
  parameter int SYM_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_vld,
  input  logic [SYM_W-1:0] upd_idx,
  input  logic             flush,
  input  logic             clr_we,
  input  logic [SYM_W-1:0] clr_addr,
  input  logic             sys_clk,
  input  logic             rd_en,
  input  logic [SYM_W-1:0] rd_idx,
  input  logic             rd_stage_en,
  output logic [CNT_W-1:0] rd_cnt
);
  localparam int DEPTH = 1 << SYM_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] mem [DEPTH];

  logic             s1_vld, s1_vld_d;
  logic [SYM_W-1:0] s1_idx;
  logic [CNT_W-1:0] rd_q;
  logic             fwd_hit;
  logic [CNT_W-1:0] fwd_val;
  logic             s2_vld, s2_vld_d;
  logic [SYM_W-1:0] s2_idx;
  logic [CNT_W-1:0] s2_val;
  logic [CNT_W-1:0] base, inc;
  logic [CNT_W-1:0] rd_q1;

  always_comb begin
    base     = fwd_hit ? fwd_val : rd_q;
    inc      = (base == CNT_MAX) ? base : base + 1'b1;
    s1_vld_d = upd_vld & ~flush;
    s2_vld_d = s1_vld & ~flush;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s1_vld <= s1_vld_d;
      s2_vld <= s2_vld_d;
    end
  end

  // datapath and RAM, sample side
  always_ff @(posedge clk) begin
    if (upd_vld) begin
      s1_idx  <= upd_idx;
      rd_q    <= mem[upd_idx];
      fwd_hit <= s2_vld && (s2_idx == upd_idx);
      fwd_val <= s2_val;
    end
    if (s1_vld) begin
      s2_idx <= s1_idx;
      s2_val <= inc;
    end
    if (clr_we) begin
      mem[clr_addr] <= '0;
    end else if (s2_vld) begin
      mem[s2_idx] <= s2_val;
    end
  end

  // RAM, system read side
  always_ff @(posedge sys_clk) begin
    if (rd_en) begin
      rd_q1 <= mem[rd_idx];
    end
    if (rd_stage_en) begin
      rd_cnt <= rd_q1;
    end
  end

  // R4
  bank_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> !upd_vld);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_vld |-> (s2_val != '0));

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !s2_vld);
endmodule

// File: rtl/pattern_hist.sv
module pattern_hist #(
  parameter int SYM_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             samp_clk,
  input  logic             samp_rst_n,
  input  logic             sym_vld,
  input  logic [SYM_W-1:0] sym,
  input  logic             sys_clk,
  input  logic             sys_rst_n,
  input  logic             rd_en,
  input  logic [SYM_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [CNT_W-1:0] rd_cnt0,
  output logic [CNT_W-1:0] rd_cnt1,
  input  logic             clr_req,
  output logic             clr_busy
);
  import hist_pkg::*;

  logic                 sweep_on;
  logic [SYM_W-1:0]     sweep_addr;
  logic                 par, par_d;
  logic [NUM_BANKS-1:0] upd_vld;
  logic [CNT_W-1:0]     bank_cnt [NUM_BANKS];
  logic                 rd_v1, rd_v2;

  hist_clr #(.SYM_W(SYM_W)) u_clr (
    .sys_clk    (sys_clk),
    .sys_rst_n  (sys_rst_n),
    .clr_req    (clr_req),
    .clr_busy   (clr_busy),
    .samp_clk   (samp_clk),
    .samp_rst_n (samp_rst_n),
    .sweep_on   (sweep_on),
    .sweep_addr (sweep_addr)
  );

  // word parity: steers even words to bank 0, odd words to bank 1
  always_comb begin
    if (sweep_on) begin
      par_d = 1'b0;
    end else if (sym_vld) begin
      par_d = ~par;
    end else begin
      par_d = par;
    end
  end

  always_ff @(posedge samp_clk or negedge samp_rst_n) begin
    if (!samp_rst_n) begin
      par <= 1'b0;
    end else begin
      par <= par_d;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign upd_vld[b] = sym_vld & ~sweep_on & (par == 1'(b));

    hist_bank #(.SYM_W(SYM_W), .CNT_W(CNT_W)) u_bank (
      .clk         (samp_clk),
      .rst_n       (samp_rst_n),
      .upd_vld     (upd_vld[b]),
      .upd_idx     (sym),
      .flush       (sweep_on),
      .clr_we      (sweep_on),
      .clr_addr    (sweep_addr),
      .sys_clk     (sys_clk),
      .rd_en       (rd_en),
      .rd_idx      (rd_idx),
      .rd_stage_en (rd_v1),
      .rd_cnt      (bank_cnt[b])
    );
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rd_v1 <= 1'b0;
      rd_v2 <= 1'b0;
    end else begin
      rd_v1 <= rd_en;
      rd_v2 <= rd_v1;
    end
  end

  assign rd_vld  = rd_v2;
  assign rd_cnt0 = bank_cnt[0];
  assign rd_cnt1 = bank_cnt[1];

  // R5
  rd_lat_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    rd_en |-> ##2 rd_vld);

  // R5
  rd_only_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    rd_vld |-> $past(rd_en, 2));

  // R3
  steer_chk: assert property (@(posedge samp_clk) disable iff (!samp_rst_n)
    (sym_vld && !sweep_on) |-> $onehot0(upd_vld) && (upd_vld != '0));
endmodule

// File: tb/tb_pattern_hist.sv
module tb_pattern_hist;
  logic       samp_clk = 1'b0;
  logic       sys_clk  = 1'b0;
  logic       samp_rst_n, sys_rst_n;
  logic       sym_vld;
  logic [9:0] sym;
  logic       rd_en;
  logic [9:0] rd_idx;
  logic       rd_vld;
  logic [15:0] rd_cnt0, rd_cnt1;
  logic       clr_req, clr_busy;

  int errors = 0;
  int checks = 0;
  int mdl [2][1024];
  int mpar = 0;

  always #4 sys_clk  = ~sys_clk;
  always #2.5 samp_clk = ~samp_clk;

  pattern_hist dut (
    .samp_clk(samp_clk), .samp_rst_n(samp_rst_n), .sym_vld(sym_vld), .sym(sym),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_vld(rd_vld), .rd_cnt0(rd_cnt0), .rd_cnt1(rd_cnt1),
    .clr_req(clr_req), .clr_busy(clr_busy)
  );

  localparam int NT = 8;
  localparam logic [9:0] T_SYM [NT] = '{10'd5, 10'd0, 10'd1023, 10'd5, 10'd300, 10'd301, 10'd900, 10'd5};
  localparam int T_REP [NT] = '{4, 3, 1, 5, 2, 2, 6, 3};
  localparam int T_GAP [NT] = '{0, 1, 0, 2, 0, 3, 1, 0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(input logic [9:0] s, input int n, input int gap, input bit mdl_on);
    for (int i = 0; i < n; i++) begin
      @(negedge samp_clk);
      sym_vld = 1'b1;
      sym     = s;
      if (mdl_on) begin
        if (mdl[mpar][s] < 65535) mdl[mpar][s]++;
        mpar ^= 1;
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge samp_clk);
        sym_vld = 1'b0;
      end
    end
    @(negedge samp_clk);
    sym_vld = 1'b0;
    repeat (6) @(negedge samp_clk);
  endtask

  task automatic read_chk(input string req, input logic [9:0] idx, input int e0, input int e1);
    logic v_early, v_late;
    @(negedge sys_clk);
    rd_en  = 1'b1;
    rd_idx = idx;
    @(negedge sys_clk);
    rd_en   = 1'b0;
    v_early = rd_vld;
    @(negedge sys_clk);
    v_late = rd_vld;
    check("R5 rd_vld one cycle after rd_en", 32'(v_early), 32'd0);
    check("R5 rd_vld two cycles after rd_en", 32'(v_late), 32'd1);
    check({req, " bank0"}, 32'(rd_cnt0), 32'(e0));
    check({req, " bank1"}, 32'(rd_cnt1), 32'(e1));
  endtask

  task automatic clr_pulse();
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 1024; i++) mdl[b][i] = 0;
    mpar = 0;
    @(negedge sys_clk);
    clr_req = 1'b1;
    @(negedge sys_clk);
    clr_req = 1'b0;
    check("R6 busy after request", 32'(clr_busy), 32'd1);
  endtask

  task automatic clr_wait();
    int n = 0;
    while (clr_busy && n < 4000) begin
      @(negedge sys_clk);
      n++;
    end
    check("R6 busy falls after sweep", 32'(clr_busy), 32'd0);
  endtask

  initial begin
    repeat (190000) @(posedge sys_clk);
    errors++;
    checks++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    samp_rst_n = 1'b0;
    sys_rst_n  = 1'b0;
    sym_vld = 1'b0;
    sym     = '0;
    rd_en   = 1'b0;
    rd_idx  = '0;
    clr_req = 1'b0;
    repeat (3) @(negedge sys_clk);
    // R8: reset state
    check("R8 rd_vld in reset", 32'(rd_vld), 32'd0);
    check("R8 busy in reset", 32'(clr_busy), 32'd0);
    samp_rst_n = 1'b1;
    sys_rst_n  = 1'b1;
    @(negedge sys_clk);
    check("R8 rd_vld after reset", 32'(rd_vld), 32'd0);
    check("R8 busy after reset", 32'(clr_busy), 32'd0);

    // R6: initial clear zeroes everything
    clr_pulse();
    clr_wait();
    read_chk("R6 cleared idx0", 10'd0, 0, 0);
    read_chk("R6 cleared idx1023", 10'd1023, 0, 0);

    // R1 R3 R4: table walk against the model
    for (int i = 0; i < NT; i++) feed(T_SYM[i], T_REP[i], T_GAP[i], 1'b1);
    for (int i = 0; i < NT; i++)
      read_chk("R1 R3 R4 table", T_SYM[i], mdl[0][T_SYM[i]], mdl[1][T_SYM[i]]);
    read_chk("R1 unfed index", 10'd600, 0, 0);

    // R7: words during the sweep are dropped
    clr_pulse();
    feed(10'd1000, 300, 0, 1'b0);
    clr_wait();
    read_chk("R7 words during sweep", 10'd1000, 0, 0);
    read_chk("R6 earlier count cleared", 10'd5, 0, 0);

    // R7 and R3: numbering restarts at bank 0
    feed(10'd3, 1, 0, 1'b1);
    read_chk("R7 first word after clear", 10'd3, 1, 0);
    feed(10'd3, 1, 0, 1'b1);
    read_chk("R3 second word to bank1", 10'd3, 1, 1);

    // R2 R4: back-to-back same symbol until saturation
    clr_pulse();
    clr_wait();
    feed(10'd7, 131080, 0, 1'b1);
    read_chk("R2 R4 saturation", 10'd7, 65535, 65535);
    read_chk("R1 neighbour untouched", 10'd8, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule